// File: doc/BRIEF.md
# Byte/Word Flash Bus Interface

This block sits between the pins of a parallel NOR-style flash and the model behind it. It sorts each combination of chip enable, output enable and write enable into an idle, read, write or conflict cycle. A width-select pin picks the data width. With width-select at 1 the bus is 16 bits wide. With width-select at 0 only the low byte carries data, and the top data pin becomes the lowest address bit. That bit chooses which half of a stored word goes out, or where a written byte lands.

Reads are combinational from pins to pins, as on the real bus. The block forms an internal address and gives it to the array. It receives a 16-bit word back, selects the lanes to drive, and drives per-bit output enables. Writes are captured when the combined strobe (chip enable OR write enable) rises. That strobe passes through a two-flop synchronizer first. Each capture leaves the block as one item on a valid/ready port. The port holds a single item. `wr_valid` stays high, with address, data and width held stable, until the consumer raises `wr_ready`. The handshake completes on the first clock edge that sees both high. A strobe edge that arrives while an item is still waiting is dropped. The bus master must hold address, data and `oe_n` stable for at least four clock cycles after the strobe rises.

Top module: `flashif_bus`

## Requirements
- R1: `cyc_kind` encodes the cycle: 0 idle when `ce_n`=1, or when `ce_n`=0 with `oe_n`=1 and `we_n`=1; 1 read when `ce_n`=0, `oe_n`=0, `we_n`=1; 2 write when `ce_n`=0, `we_n`=0, `oe_n`=1; 3 conflict when all three are 0.
- R2: In a read cycle with `wide`=1, `dq_oe` is all ones and `dq_out` equals `rd_data`.
- R3: In a read cycle with `wide`=0, `dq_oe` is 16'h00FF. `dq_out[7:0]` is `rd_data[7:0]` when `dq_in[15]`=0 and `rd_data[15:8]` when `dq_in[15]`=1. `dq_out[15:8]` is 0.
- R4: In idle, write and conflict cycles `dq_oe` is 0, whatever the level of `oe_n`.
- R5: `rd_addr` is `{addr, lsb}`, where lsb is `dq_in[15]` when `wide`=0 and 0 when `wide`=1.
- R6: When `ce_n|we_n` rises after a write cycle with `oe_n`=1 and `wide`=1, one item appears on the write port with `wr_data`=`dq_in`, `wr_word`=1 and `wr_addr`={`addr`,0}. `wr_valid` rises on the third clock edge after the strobe rise.
- R7: With `wide`=0, a captured write carries `wr_data`={8'h00,`dq_in[7:0]`}, `wr_word`=0 and `wr_addr`={`addr`,`dq_in[15]`}.
- R8: While `wr_valid`=1 and `wr_ready`=0, the item stays valid with all fields stable. After a handshake edge, `wr_valid` is 0.
- R9: A strobe rise that comes while an item is pending is dropped. The pending item is delivered unchanged.
- R10: A strobe rise that ends a conflict cycle (`oe_n`=0) produces no write item.
- R11: After reset `wr_valid` is 0. No strobe edge is seen out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wide | input | 1 | Width select: 1 word, 0 byte |
| addr | input | AW | Word address pins |
| dq_in | input | DW | Data pins as seen from the bus |
| dq_out | output | DW | Data driven toward the pins |
| dq_oe | output | DW | Per-bit output enable |
| cyc_kind | output | 2 | Decoded cycle kind (R1) |
| rd_addr | output | AW+1 | Byte-granular read address to the array |
| rd_data | input | DW | Word returned by the array |
| wr_valid | output | 1 | Write item available |
| wr_ready | input | 1 | Consumer accepts the item |
| wr_addr | output | AW+1 | Byte-granular write address |
| wr_data | output | DW | Write data |
| wr_word | output | 1 | 1 for a word write, 0 for a byte write |

## Verification
The bench uses byte-mode reads with the top pin at both levels. A lane mux with the wrong polarity would return the wrong half of the word, and a design that forgot the mode would leave the upper enables on. Standby with `oe_n` low, and the all-low conflict cycle, are both checked to drive nothing. A design that gated only on `oe_n` would drive the bus in those cycles. The write port is held stalled while a second write arrives. A design that overwrites its pending item would deliver the wrong data, and one that queues would deliver an extra item. A write that ends with `oe_n` low must leave no item on the scoreboard.

// File: rtl/flashif_pkg.sv
package flashif_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE     = 2'd0,
    CYC_READ     = 2'd1,
    CYC_WRITE    = 2'd2,
    CYC_CONFLICT = 2'd3
  } cyc_e;
endpackage

// File: rtl/flashif_cycle_decode.sv
module flashif_cycle_decode
  import flashif_pkg::*;
(
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output cyc_e kind
);
  always_comb begin
    if (ce_n)                kind = CYC_IDLE;
    else if (!oe_n && !we_n) kind = CYC_CONFLICT;
    else if (!oe_n)          kind = CYC_READ;
    else if (!we_n)          kind = CYC_WRITE;
    else                     kind = CYC_IDLE;
  end
endmodule

// File: rtl/flashif_sync.sv
module flashif_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/flashif_wr_capture.sv
module flashif_wr_capture #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_q,
  input  logic          oe_q,
  input  logic          wide,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  input  logic          wr_ready,
  output logic          wr_valid,
  output logic [AW:0]   wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_word
);
  localparam int HALF = DW / 2;

  logic strobe_d;
  logic rise;
  logic take;
  logic lsb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_d <= 1'b1;
    else        strobe_d <= strobe_q;
  end

  assign rise = strobe_q & ~strobe_d;
  assign take = rise & oe_q & ~wr_valid;
  assign lsb  = wide ? 1'b0 : dq_in[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_word  <= 1'b0;
    end else if (take) begin
      wr_valid <= 1'b1;
      wr_addr  <= {addr, lsb};
      wr_word  <= wide;
      wr_data  <= wide ? dq_in : {{(DW-HALF){1'b0}}, dq_in[HALF-1:0]};
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/flashif_rd_drive.sv
module flashif_rd_drive
  import flashif_pkg::*;
#(
  parameter int DW = 16
) (
  input  cyc_e          kind,
  input  logic          wide,
  input  logic          lane_hi,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] dq_oe
);
  localparam int HALF = DW / 2;

  logic reading;
  assign reading = (kind == CYC_READ);

  for (genvar i = 0; i < DW; i++) begin : g_oe
    if (i < HALF) begin : g_low
      assign dq_oe[i] = reading;
    end else begin : g_high
      assign dq_oe[i] = reading & wide;
    end
  end

  always_comb begin
    if (wide)         dq_out = rd_data;
    else if (lane_hi) dq_out = {{(DW-HALF){1'b0}}, rd_data[DW-1:HALF]};
    else              dq_out = {{(DW-HALF){1'b0}}, rd_data[HALF-1:0]};
  end
endmodule

// File: rtl/flashif_bus.sv
module flashif_bus
  import flashif_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          wide,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] dq_oe,
  output logic [1:0]    cyc_kind,
  output logic [AW:0]   rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW:0]   wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_word
);
  cyc_e kind;
  logic lane_hi;
  logic strobe_q;
  logic oe_q;

  assign lane_hi  = ~wide & dq_in[DW-1];
  assign rd_addr  = {addr, lane_hi};
  assign cyc_kind = kind;

  flashif_cycle_decode u_dec (
    .ce_n (ce_n),
    .oe_n (oe_n),
    .we_n (we_n),
    .kind (kind)
  );

  flashif_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_strobe (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ce_n | we_n),
    .q     (strobe_q)
  );

  flashif_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_oe (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (oe_n),
    .q     (oe_q)
  );

  flashif_wr_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_q (strobe_q),
    .oe_q     (oe_q),
    .wide     (wide),
    .addr     (addr),
    .dq_in    (dq_in),
    .wr_ready (wr_ready),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_word  (wr_word)
  );

  flashif_rd_drive #(.DW(DW)) u_rd (
    .kind    (kind),
    .wide    (wide),
    .lane_hi (lane_hi),
    .rd_data (rd_data),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe)
  );
endmodule

// File: rtl/flashif_bus_chk.sv
module flashif_bus_chk #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          wide,
  input logic [DW-1:0] dq_oe,
  input logic [AW:0]   rd_addr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW:0]   wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          wr_word
);
  localparam int HALF = DW / 2;

  assert_standby_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> dq_oe == '0);

  assert_conflict_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !we_n) |-> dq_oe == '0);

  assert_byte_upper_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> dq_oe[DW-1:HALF] == '0);

  assert_read_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && we_n && wide) |-> &dq_oe);

  assert_word_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wide |-> rd_addr[0] == 1'b0);

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr) && $stable(wr_word)));

  assert_clear_after_hs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_valid);

  assert_byte_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_word) |-> wr_data[DW-1:HALF] == '0);
endmodule

bind flashif_bus flashif_bus_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .we_n     (we_n),
  .wide     (wide),
  .dq_oe    (dq_oe),
  .rd_addr  (rd_addr),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .wr_word  (wr_word)
);

// File: tb/flashif_bus_tb.sv
`timescale 1ns/1ps
module flashif_bus_tb;
  localparam int AW = 20;
  localparam int DW = 16;

  typedef struct packed {
    logic [AW:0]   a;
    logic [DW-1:0] d;
    logic          w;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wide = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0, rd_data = '0;
  logic [DW-1:0] dq_out, dq_oe, wr_data;
  logic [1:0]    cyc_kind;
  logic [AW:0]   rd_addr, wr_addr;
  logic          wr_valid, wr_word;
  logic          wr_ready = 1'b1;

  int checks = 0;
  int fails = 0;
  int delivered = 0;
  bit done = 0;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  flashif_bus #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wide(wide), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .cyc_kind(cyc_kind), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_word(wr_word)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic c, input logic o, input logic w);
    ce_n = c; oe_n = o; we_n = w;
    #1;
  endtask

  // Monitor: pops the scoreboard on every handshake
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      delivered++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9/R10 unexpected write item", {wr_word, wr_addr, wr_data}, 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk(wr_addr == e.a, "R6/R7 wr_addr", wr_addr, e.a);
        chk(wr_data == e.d, "R6/R7 wr_data", wr_data, e.d);
        chk(wr_word == e.w, "R6/R7 wr_word", wr_word, e.w);
      end
    end
  end

  task automatic do_write(input logic wv, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic oe_lvl, input bit expect_item);
    @(negedge clk);
    wide = wv; addr = a; dq_in = d; oe_n = oe_lvl;
    ce_n = 1'b0; we_n = 1'b0;
    repeat (3) @(negedge clk);
    if (expect_item) begin
      item_t e;
      e.a = {a, wv ? 1'b0 : d[DW-1]};
      e.d = wv ? d : {8'h00, d[7:0]};
      e.w = wv;
      exp_q.push_back(e);
    end
    we_n = 1'b1; ce_n = 1'b1;
    repeat (6) @(negedge clk);
    oe_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(wr_valid == 1'b0, "R11 wr_valid in reset", wr_valid, 0);
    chk(dq_oe == '0, "R11 dq_oe in reset", dq_oe, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(wr_valid == 1'b0, "R11 no edge after reset", wr_valid, 0);

    // R1 decode
    bus(1, 0, 1); chk(cyc_kind == 2'd0, "R1 standby idle", cyc_kind, 0);
    bus(0, 1, 1); chk(cyc_kind == 2'd0, "R1 selected idle", cyc_kind, 0);
    bus(0, 0, 1); chk(cyc_kind == 2'd1, "R1 read", cyc_kind, 1);
    bus(0, 1, 0); chk(cyc_kind == 2'd2, "R1 write", cyc_kind, 2);
    bus(0, 0, 0); chk(cyc_kind == 2'd3, "R1 conflict", cyc_kind, 3);

    // R4 no drive outside reads
    chk(dq_oe == '0, "R4 conflict no drive", dq_oe, 0);
    bus(1, 0, 1); chk(dq_oe == '0, "R4 standby oe_n low", dq_oe, 0);
    bus(0, 1, 0); chk(dq_oe == '0, "R4 write no drive", dq_oe, 0);

    // R2 word read
    wide = 1; addr = 20'h1234A; rd_data = 16'hBEEF; dq_in = 16'h8000;
    bus(0, 0, 1);
    chk(dq_oe == 16'hFFFF, "R2 word oe", dq_oe, 16'hFFFF);
    chk(dq_out == 16'hBEEF, "R2 word data", dq_out, 16'hBEEF);
    chk(rd_addr == {20'h1234A, 1'b0}, "R5 word address lsb 0", rd_addr, {20'h1234A, 1'b0});

    // R3 byte reads, both lanes
    wide = 0; rd_data = 16'hA55A; dq_in = 16'h0000; #1;
    chk(dq_oe == 16'h00FF, "R3 byte oe", dq_oe, 16'h00FF);
    chk(dq_out == 16'h005A, "R3 low lane", dq_out, 16'h005A);
    chk(rd_addr == {20'h1234A, 1'b0}, "R5 byte address lsb 0", rd_addr, {20'h1234A, 1'b0});
    dq_in = 16'h8000; #1;
    chk(dq_out == 16'h00A5, "R3 high lane", dq_out, 16'h00A5);
    chk(rd_addr == {20'h1234A, 1'b1}, "R5 byte address lsb 1", rd_addr, {20'h1234A, 1'b1});
    bus(1, 1, 1);

    // R6 word write with latency
    @(negedge clk);
    wide = 1; addr = 20'h00F0F; dq_in = 16'hC3A1; oe_n = 1;
    ce_n = 0; we_n = 0;
    repeat (3) @(negedge clk);
    begin
      item_t e;
      e.a = {20'h00F0F, 1'b0}; e.d = 16'hC3A1; e.w = 1'b1;
      exp_q.push_back(e);
    end
    wr_ready = 0;
    #0.5 we_n = 1; ce_n = 1;
    @(negedge clk); @(negedge clk);
    chk(wr_valid == 1'b0, "R6 not valid after two edges", wr_valid, 0);
    @(negedge clk);
    chk(wr_valid == 1'b1, "R6 valid on third edge", wr_valid, 1);
    wr_ready = 1;
    repeat (4) @(negedge clk);

    // R7 byte writes to both lanes
    do_write(0, 20'h0ABCD, 16'h807E, 1, 1);
    do_write(0, 20'h0ABCD, 16'h7F11, 1, 1);

    // R10 conflict ending edge
    do_write(1, 20'h00001, 16'h1111, 0, 0);

    // R8/R9 stall, second write dropped
    wr_ready = 0;
    do_write(1, 20'h00002, 16'h2222, 1, 1);
    do_write(1, 20'h00003, 16'h3333, 1, 0);
    chk(wr_valid == 1'b1, "R8 held during stall", wr_valid, 1);
    chk(wr_data == 16'h2222, "R9 pending item kept", wr_data, 16'h2222);
    @(negedge clk) wr_ready = 1;
    repeat (8) @(negedge clk);

    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    chk(delivered == 4, "R9/R10 item count", delivered, 4);
    chk(wr_valid == 1'b0, "R8 cleared after handshake", wr_valid, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule